// File: doc/BRIEF.md
# PC Card Socket Space Router

This block connects a host bus slave port to one removable card. The host sees a 256 MB socket window. The top two offset bits pick one of four 64 MB regions: card I/O space, a reserved hole, attribute memory, or common memory. An access to a card region goes out on the card port with a two-bit space code and a 26-bit offset. A read or write strobe reaches the card only while a card is present and the offset is outside the reserved hole. Read data comes back one clock after the read strobe and is zero whenever the access did not reach the card.

A small slot state machine handles card insertion and ejection requests. Its states are EMPTY, SEATING, SEATED and RELEASING. It has four transitions:
- EMPTY goes to SEATING on an accepted insert.
- SEATING goes to SEATED unconditionally.
- SEATED goes to RELEASING on an accepted eject.
- RELEASING goes to EMPTY unconditionally.

Every request gets a one-cycle response with a status code. The block drives the card-detect interrupt. It also passes the card's interrupt level through to the host while a card is present.

Top module: `pcc_socket_router`

## Requirements
- R1: With a card present, host offset bits [27:26] give the card space code on `card_space`: 0 is I/O, 2 is attribute memory and 3 is common memory. `card_offset` carries offset bits [25:0], and `card_wdata` carries `host_wdata`.
- R2: Offsets whose bits [27:26] equal 1 fall in the reserved hole. They never assert `card_rd` or `card_wr`, and a read there returns zero, even with a card present.
- R3: While `card_present` is low, `card_rd` and `card_wr` stay low and every read returns zero.
- R4: `host_size` is copied to `card_size`, and the access width never changes the decode.
- R5: `host_rvalid` is high exactly one cycle after `host_rd`. In that cycle `host_rdata` holds the `card_rdata` value from the strobe cycle.
- R6: An insert in EMPTY moves the slot to SEATING on the next cycle. In SEATING, `card_attach` is high for one cycle and `card_present` and `cd_irq` go high. The slot then enters SEATED. The response code is 0.
- R7: An insert in SEATED is answered with code 1 (occupied), and the slot state does not change.
- R8: An eject in EMPTY is answered with code 2 (no card), and the slot state does not change.
- R9: An eject in SEATED moves the slot to RELEASING. There `card_detach` pulses for one cycle, `card_present` drops, and `cd_irq` and `host_irq` are low. The slot then enters EMPTY. The response code is 0.
- R10: Any request made in SEATING or RELEASING is answered with code 3 (busy) and changes nothing. When insert and eject are requested together, only the insert is taken.
- R11: `host_irq` follows `card_irq_in` combinationally while `card_present` is high and is low otherwise.
- R12: Each request is answered on the next cycle: `req_done` is high for one cycle and `req_err` carries the code.
- R13: A synchronous active-high `rst` returns the slot to EMPTY and clears `card_present`, `cd_irq`, `host_irq`, `req_done` and `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 28 | Offset inside the socket window |
| host_size | input | 2 | Access width code |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| insert_req | input | 1 | Card insertion request |
| eject_req | input | 1 | Card ejection request |
| req_done | output | 1 | Request answered |
| req_err | output | 2 | Response code: 0 ok, 1 occupied, 2 no card, 3 busy |
| card_rd | output | 1 | Read strobe to the card |
| card_wr | output | 1 | Write strobe to the card |
| card_space | output | 2 | Card space code |
| card_offset | output | 26 | Offset inside the card space |
| card_size | output | 2 | Access width code to the card |
| card_wdata | output | 32 | Write data to the card |
| card_rdata | input | 32 | Card read data, valid in the strobe cycle |
| card_attach | output | 1 | Attach notification pulse |
| card_detach | output | 1 | Detach notification pulse |
| card_irq_in | input | 1 | Card interrupt request level |
| card_present | output | 1 | Card present flag |
| host_irq | output | 1 | Card interrupt to the host |
| cd_irq | output | 1 | Card-detect interrupt |

## Verification
The assertions assume three things about the inputs. Host strobes last one cycle. At most one of `host_rd` and `host_wr` is high in a cycle. The card returns `card_rdata` in the same cycle as its read strobe. The stimulus keeps to all three: it drives every access as a single-cycle strobe of one kind, and it models the card as a combinational function of `card_space` and `card_offset`. Insert and eject requests are the exception. They are deliberately placed in every slot state, including the two transient ones and a cycle with both requests high, so that the busy path and the insert-wins rule are covered.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY     = 2'd0,
        SLOT_SEATING   = 2'd1,
        SLOT_SEATED    = 2'd2,
        SLOT_RELEASING = 2'd3
    } slot_state_t;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_OCCUPIED = 2'd1,
        RSP_NOCARD   = 2'd2,
        RSP_BUSY     = 2'd3
    } req_rsp_t;

    localparam logic [1:0] SPC_IO     = 2'd0;
    localparam logic [1:0] SPC_RSVD   = 2'd1;
    localparam logic [1:0] SPC_ATTR   = 2'd2;
    localparam logic [1:0] SPC_COMMON = 2'd3;
endpackage

// File: rtl/pcc_space_decode.sv
module pcc_space_decode
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        space,
    output logic [ADDR_W-3:0] offset,
    output logic              reserved
);
    always_comb begin
        space    = addr[ADDR_W-1 -: 2];
        offset   = addr[ADDR_W-3:0];
        reserved = (space == SPC_RSVD);
    end
endmodule

// File: rtl/pcc_slot_fsm.sv
module pcc_slot_fsm
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       insert_req,
    input  logic       eject_req,
    output logic       present,
    output logic       attach,
    output logic       detach,
    output logic       cd_irq,
    output logic       req_done,
    output logic [1:0] req_err
);
    slot_state_t state, nxt;
    req_rsp_t    rsp;
    logic        ins_ok, ej_ok, any_req;

    always_comb begin
        any_req = insert_req || eject_req;
        ins_ok  = insert_req && (state == SLOT_EMPTY);
        ej_ok   = eject_req && !insert_req && (state == SLOT_SEATED);
        nxt     = state;
        unique case (state)
            SLOT_EMPTY:     nxt = ins_ok ? SLOT_SEATING : SLOT_EMPTY;
            SLOT_SEATING:   nxt = SLOT_SEATED;
            SLOT_SEATED:    nxt = ej_ok ? SLOT_RELEASING : SLOT_SEATED;
            SLOT_RELEASING: nxt = SLOT_EMPTY;
        endcase
        rsp = RSP_OK;
        if (insert_req) begin
            if (state == SLOT_SEATED)     rsp = RSP_OCCUPIED;
            else if (state != SLOT_EMPTY) rsp = RSP_BUSY;
        end else if (eject_req) begin
            if (state == SLOT_EMPTY)       rsp = RSP_NOCARD;
            else if (state != SLOT_SEATED) rsp = RSP_BUSY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SLOT_EMPTY;
            cd_irq   <= 1'b0;
            req_done <= 1'b0;
            req_err  <= RSP_OK;
        end else begin
            state    <= nxt;
            req_done <= any_req;
            req_err  <= any_req ? rsp : RSP_OK;
            if (ins_ok)     cd_irq <= 1'b1;
            else if (ej_ok) cd_irq <= 1'b0;
        end
    end

    always_comb begin
        present = 1'b0;
        attach  = 1'b0;
        detach  = 1'b0;
        unique case (state)
            SLOT_EMPTY:     ;
            SLOT_SEATING:   begin present = 1'b1; attach = 1'b1; end
            SLOT_SEATED:    present = 1'b1;
            SLOT_RELEASING: detach = 1'b1;
        endcase
    end

    assert_attach_after_insert_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_EMPTY && insert_req) |=> (attach && cd_irq && req_done && req_err == RSP_OK));
    assert_nocard_on_empty_eject_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_EMPTY && eject_req && !insert_req) |=> (req_done && req_err == RSP_NOCARD && !present));
    assert_occupied_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_SEATED && insert_req) |=> (present && !attach && req_err == RSP_OCCUPIED));
    assert_detach_clears_cd_R9: assert property (@(posedge clk) disable iff (rst)
        detach |-> (!cd_irq && !present));
endmodule

// File: rtl/pcc_access_path.sv
module pcc_access_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              present,
    input  logic              reserved,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] card_rdata,
    output logic              card_rd,
    output logic              card_wr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);
    logic route_ok;

    always_comb begin
        route_ok = present && !reserved;
        card_rd  = host_rd && route_ok;
        card_wr  = host_wr && route_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= card_rd ? card_rdata : '0;
        end
    end

    assert_rvalid_follows_rd_R5: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);
    assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !present) |=> (host_rdata == '0));
    assert_hole_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (host_rd && reserved) |=> (host_rdata == '0));
endmodule

// File: rtl/pcc_socket_router.sv
module pcc_socket_router
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [SIZE_W-1:0] host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              insert_req,
    input  logic              eject_req,
    output logic              req_done,
    output logic [1:0]        req_err,
    output logic              card_rd,
    output logic              card_wr,
    output logic [1:0]        card_space,
    output logic [ADDR_W-3:0] card_offset,
    output logic [SIZE_W-1:0] card_size,
    output logic [DATA_W-1:0] card_wdata,
    input  logic [DATA_W-1:0] card_rdata,
    output logic              card_attach,
    output logic              card_detach,
    input  logic              card_irq_in,
    output logic              card_present,
    output logic              host_irq,
    output logic              cd_irq
);
    localparam int OFS_W = ADDR_W - 2;

    logic             in_hole;
    logic [OFS_W-1:0] ofs;

    pcc_space_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(host_addr), .space(card_space), .offset(ofs), .reserved(in_hole)
    );

    pcc_slot_fsm u_slot (
        .clk(clk), .rst(rst), .insert_req(insert_req), .eject_req(eject_req),
        .present(card_present), .attach(card_attach), .detach(card_detach),
        .cd_irq(cd_irq), .req_done(req_done), .req_err(req_err)
    );

    pcc_access_path #(.DATA_W(DATA_W)) u_path (
        .clk(clk), .rst(rst), .present(card_present), .reserved(in_hole),
        .host_rd(host_rd), .host_wr(host_wr), .card_rdata(card_rdata),
        .card_rd(card_rd), .card_wr(card_wr),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    always_comb begin
        card_offset = ofs;
        card_size   = host_size;
        card_wdata  = host_wdata;
        host_irq    = card_irq_in && card_present;
    end

    assert_irq_quiet_on_detach_R9: assert property (@(posedge clk) disable iff (rst)
        card_detach |-> !host_irq);
    assert_no_hole_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (card_rd || card_wr) |-> (card_space != SPC_RSVD && card_present));
endmodule

// File: tb/pcc_socket_router_test.sv
`timescale 1ns/1ps
module pcc_socket_router_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rd = 0, host_wr = 0, insert_req = 0, eject_req = 0, card_irq_in = 0;
    logic [27:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, card_rdata, card_wdata;
    logic        host_rvalid, req_done, card_rd, card_wr, card_attach, card_detach;
    logic        card_present, host_irq, cd_irq;
    logic [1:0]  req_err, card_space, card_size;
    logic [25:0] card_offset;

    always #2 clk = ~clk;

    // card model: data depends on space and offset only
    assign card_rdata = {card_space, card_offset, 4'hA};

    pcc_socket_router uut (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .insert_req(insert_req), .eject_req(eject_req),
        .req_done(req_done), .req_err(req_err),
        .card_rd(card_rd), .card_wr(card_wr), .card_space(card_space),
        .card_offset(card_offset), .card_size(card_size), .card_wdata(card_wdata),
        .card_rdata(card_rdata), .card_attach(card_attach), .card_detach(card_detach),
        .card_irq_in(card_irq_in), .card_present(card_present),
        .host_irq(host_irq), .cd_irq(cd_irq)
    );

    int nchk = 0, nbad = 0, ncyc = 0;
    bit started = 0;

    // behavioural reference model: 0 empty, 1 seating, 2 seated, 3 releasing
    int m_st = 0, m_err = 0;
    bit m_cd = 0, m_done = 0, m_rv = 0;
    logic [31:0] m_rdata = '0;

    always @(posedge clk) begin
        bit pres;
        started = 1;
        pres = (m_st == 1 || m_st == 2);
        if (rst) begin
            m_st = 0; m_cd = 0; m_done = 0; m_err = 0; m_rv = 0; m_rdata = '0;
        end else begin
            m_rv = host_rd;
            if (host_rd)
                m_rdata = (pres && host_addr[27:26] != 2'd1) ? {host_addr, 4'hA} : 32'h0;
            m_done = insert_req || eject_req;
            m_err = 0;
            if (insert_req) begin
                if (m_st == 0) begin m_st = 1; m_cd = 1; end
                else if (m_st == 2) m_err = 1;
                else begin m_err = 3; m_st = (m_st == 1) ? 2 : 0; end
            end else if (eject_req) begin
                if (m_st == 2) begin m_st = 3; m_cd = 0; end
                else if (m_st == 0) m_err = 2;
                else begin m_err = 3; m_st = (m_st == 1) ? 2 : 0; end
            end else if (m_st == 1) m_st = 2;
            else if (m_st == 3) m_st = 0;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit pres, fwd;
        if (started) begin
            pres = (m_st == 1 || m_st == 2);
            fwd  = pres && host_addr[27:26] != 2'd1;
            chk("R13/R6/R9", "card_present", card_present, pres);
            chk("R6", "card_attach", card_attach, m_st == 1);
            chk("R9", "card_detach", card_detach, m_st == 3);
            chk("R6/R9", "cd_irq", cd_irq, m_cd);
            chk("R11", "host_irq", host_irq, card_irq_in && pres);
            chk("R12", "req_done", req_done, m_done);
            if (m_done) chk("R7/R8/R10", "req_err", req_err, m_err);
            chk("R5", "host_rvalid", host_rvalid, m_rv);
            if (m_rv) chk("R5/R2/R3", "host_rdata", host_rdata, m_rdata);
            chk("R2/R3", "card_rd", card_rd, host_rd && fwd);
            chk("R2/R3", "card_wr", card_wr, host_wr && fwd);
            if (fwd) begin
                chk("R1", "card_space", card_space, host_addr[27:26]);
                chk("R1", "card_offset", card_offset, host_addr[25:0]);
                chk("R1", "card_wdata", card_wdata, host_wdata);
            end
            chk("R4", "card_size", card_size, host_size);
        end
    end

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 20000) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    task automatic step(bit rd, bit wr, logic [27:0] a, logic [1:0] sz, bit ins, bit ej);
        host_rd = rd; host_wr = wr; host_addr = a; host_size = sz;
        host_wdata = {a[15:0], ~a[15:0]};
        insert_req = ins; eject_req = ej;
        @(negedge clk); #1;
        host_rd = 0; host_wr = 0; insert_req = 0; eject_req = 0;
    endtask

    task automatic sweep(int seed);
        for (int i = 0; i < 16; i++) begin
            logic [27:0] a;
            a = 28'(i * 32'h0400_0000 / 4 + seed * 32'h0013_579B);
            step(1, 0, a, 2'(i), 0, 0);
            step(0, 1, a ^ 28'h0ABCDEF, 2'(i + 1), 0, 0);
            step(1, 0, {2'(i), 26'h3FFFFFF}, 2'(i), 0, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        sweep(1);                       // R3: empty socket
        step(0, 0, '0, 0, 0, 1);        // R8: eject on empty
        step(0, 0, '0, 0, 0, 0);
        step(0, 0, '0, 0, 1, 0);        // R6: insert
        step(0, 0, '0, 0, 1, 0);        // R10: insert while seating
        step(0, 0, '0, 0, 1, 0);        // R7: occupied
        step(0, 0, '0, 0, 0, 0);
        sweep(2);                       // R1 R2 R4 R5
        card_irq_in = 1;                // R11
        step(1, 0, 28'h8000010, 2, 0, 0);
        card_irq_in = 0;
        step(0, 0, '0, 0, 0, 0);
        card_irq_in = 1;
        step(0, 0, '0, 0, 0, 1);        // R9: eject
        step(0, 0, '0, 0, 0, 1);        // R10: eject while releasing
        step(0, 0, '0, 0, 0, 0);
        sweep(3);
        step(0, 0, '0, 0, 1, 1);        // R10: both, insert wins
        step(0, 0, '0, 0, 0, 1);        // R10: eject while seating
        step(0, 0, '0, 0, 0, 0);
        step(0, 0, '0, 0, 1, 1);        // R7: both while seated
        card_irq_in = 0;
        step(1, 0, 28'hC000004, 0, 0, 0);
        rst = 1;                        // R13: reset with card in
        step(0, 0, '0, 0, 0, 0);
        step(0, 0, '0, 0, 0, 0);
        rst = 0;
        step(1, 0, 28'hC000004, 0, 0, 0);
        step(0, 0, '0, 0, 0, 0);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule